// File: doc/BRIEF.md
# Wide-Fetch Audio Sample Unpacker

This block is a single audio playback channel. It fetches sample data from memory in units of 16, 32 or 64 bits and keeps each fetch in an internal buffer. It then hands the samples to a 16-bit DAC output one at a time, advancing to the next sample every programmed period. A mode input selects 8-bit or 16-bit samples. One fetch therefore feeds between one and eight samples, so a wider fetch or narrower samples allow a higher playback rate for the same single memory slot per fetch.

The channel asks for data with `fetch_req` and presents the aligned fetch address on `fetch_addr`. An outside arbiter answers with `fetch_grant` and the fetched word. A length counter, counted in fetch units, sends the address back to the start once the programmed number of fetches is done, so the sample buffer loops. With 8-bit samples and 16-bit fetches, the channel plays two samples per word, most significant byte first. This is the classic narrow-channel behaviour.

Top module: `wide_audio_chan`

## Requirements
- R1: After reset, `sample_out` is 0, `fetch_req` is 0 and `fetch_addr` is 0.
- R2: When the channel is enabled with an empty buffer, `fetch_req` goes high at the next clock edge. A grant taken while `fetch_req` is high loads the buffer and clears `fetch_req` at that same edge.
- R3: `width_sel` codes 0, 1 and 2 select 16-, 32- and 64-bit fetches, and code 3 also selects 64 bits. The fetched bits are the low 16, 32 or 64 bits of `fetch_data`. One fetch yields 2, 4 or 8 samples with `wide_mode`=0, and 1, 2 or 4 samples with `wide_mode`=1.
- R4: Samples play in big-endian order: the most significant byte (or halfword) of the fetched field comes first.
- R5: An 8-bit sample appears as {sample, 8'h00} on `sample_out`. A 16-bit sample appears unchanged.
- R6: The first sample of a loaded buffer appears one clock edge after the load edge. Each following sample appears exactly `period` edges after the previous one and is held in between. A period of 0 acts as 1.
- R7: `fetch_req` rises at the same edge where the last buffered sample appears. It stays high until a grant arrives.
- R8: If the period runs out while the buffer is empty, `sample_out` holds its value. The first new sample appears one edge after the grant's load edge.
- R9: `fetch_addr` is the start address with its low bits cleared for the fetch size: 1 bit for 16, 2 bits for 32 and 3 bits for 64. Each accepted grant steps the address by the fetch size in bytes.
- R10: After `length_units` accepted grants, the address returns to the aligned start address. A length of 0 acts as 1.
- R11: With `chan_en` low, the next edge clears `sample_out` and `fetch_req`, empties the buffer and reloads the address from the start.
- R12: A `fetch_grant` while `fetch_req` is low is ignored: the address and the buffered samples are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable; low stops and clears playback |
| width_sel | input | 2 | Fetch width: 0=16, 1=32, 2/3=64 bits |
| wide_mode | input | 1 | 1 selects 16-bit samples, 0 selects 8-bit |
| period | input | PER_W (16) | Clock cycles per sample |
| start_addr | input | ADDR_W (24) | Byte address of the sample buffer |
| length_units | input | LEN_W (16) | Buffer length in fetch units |
| fetch_req | output | 1 | Request for a memory fetch |
| fetch_addr | output | ADDR_W (24) | Aligned address of the requested fetch |
| fetch_grant | input | 1 | Fetch slot granted; data valid this cycle |
| fetch_data | input | 64 | Fetched data, right-justified |
| sample_out | output | 16 | Current sample for the DAC |

## Verification
The following results are due at these edges:
- `fetch_req` is due one edge after enable.
- The buffer load happens at the grant edge, and the first sample follows one edge later.
- Each later sample is due exactly `period` edges after the one before.
- Requests, address steps and disable effects land one edge after their cause.

The bench drives inputs and samples outputs on the falling edge, so every check reads the value registered at the preceding rising edge. It counts edges from the stimulus to the due edge. For periods longer than one, it also checks the old sample one edge before the change, to show it was held and did not move early.

// File: rtl/wac_pkg.sv
package wac_pkg;

    typedef enum logic [1:0] {
        FW_16  = 2'd0,
        FW_32  = 2'd1,
        FW_64  = 2'd2,
        FW_64B = 2'd3
    } fetch_w_e;

    // bytes moved by one fetch of the selected width
    function automatic logic [3:0] fetch_bytes(input logic [1:0] wsel);
        logic [3:0] nb;
        case (fetch_w_e'(wsel))
            FW_16:   nb = 4'd2;
            FW_32:   nb = 4'd4;
            default: nb = 4'd8;
        endcase
        return nb;
    endfunction

    // samples delivered by one fetch for the width and sample size
    function automatic logic [3:0] samples_per_fetch(input logic [1:0] wsel,
                                                     input logic       wide);
        logic [3:0] nb;
        nb = fetch_bytes(wsel);
        return wide ? (nb >> 1) : nb;
    endfunction

endpackage

// File: rtl/wac_timer.sv
module wac_timer #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PER_W-1:0] period,
    input  logic             reload,
    output logic             expired
);

    typedef struct packed {
        logic [PER_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!en) begin
            tmr_d.cnt = '0;
        end else if (reload) begin
            // a sample just started: it lasts 'period' cycles in total
            tmr_d.cnt = (period == '0) ? '0 : period - 1'b1;
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign expired = (tmr_q.cnt == '0);

endmodule

// File: rtl/wac_fetch_ctl.sv
module wac_fetch_ctl #(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [1:0]        width_sel,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  length_units,
    input  logic              grant_ok,
    output logic [ADDR_W-1:0] fetch_addr
);
    import wac_pkg::*;

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic [LEN_W-1:0]  left;
    } fctl_t;

    fctl_t fc_d, fc_q;

    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] low_mask;
    logic [ADDR_W-1:0] start_al;

    always_comb begin
        step     = ADDR_W'(fetch_bytes(width_sel));
        low_mask = step - 1'b1;
        start_al = start_addr & ~low_mask;

        fc_d = fc_q;
        if (!en) begin
            fc_d.ptr  = start_al;
            fc_d.left = length_units;
        end else if (grant_ok) begin
            if (fc_q.left <= LEN_W'(1)) begin
                // last unit of the buffer: loop back to the start
                fc_d.ptr  = start_al;
                fc_d.left = length_units;
            end else begin
                fc_d.ptr  = fc_q.ptr + step;
                fc_d.left = fc_q.left - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fc_q <= '0;
        else        fc_q <= fc_d;
    end

    assign fetch_addr = fc_q.ptr & ~low_mask;

endmodule

// File: rtl/wac_sample_buf.sv
module wac_sample_buf #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [1:0]        width_sel,
    input  logic              wide_mode,
    input  logic              expired,
    input  logic              grant_ok,
    input  logic [DATA_W-1:0] fetch_data,
    output logic              take,
    output logic              req,
    output logic [15:0]       sample
);
    import wac_pkg::*;

    localparam int CNT_W = $clog2(DATA_W / 8 + 1);
    localparam int SH_W  = $clog2(DATA_W + 1);

    typedef struct packed {
        logic [DATA_W-1:0] pbuf;   // left-justified unplayed samples
        logic [CNT_W-1:0]  left;   // samples still in pbuf
        logic              wide;   // sample size latched at load
        logic [15:0]       smp;
        logic              req;
    } sbuf_t;

    sbuf_t sb_d, sb_q;

    logic [SH_W-1:0] load_sh;

    assign take = en && expired && (sb_q.left != '0);

    always_comb begin
        load_sh = SH_W'(DATA_W) - SH_W'({fetch_bytes(width_sel), 3'b000});
        sb_d    = sb_q;
        if (!en) begin
            sb_d = '0;
        end else begin
            if (take) begin
                if (sb_q.wide) begin
                    sb_d.smp  = sb_q.pbuf[DATA_W-1 -: 16];
                    sb_d.pbuf = sb_q.pbuf << 16;
                end else begin
                    sb_d.smp  = {sb_q.pbuf[DATA_W-1 -: 8], 8'h00};
                    sb_d.pbuf = sb_q.pbuf << 8;
                end
                sb_d.left = sb_q.left - 1'b1;
            end else if (grant_ok && (sb_q.left == '0)) begin
                sb_d.pbuf = fetch_data << load_sh;
                sb_d.left = CNT_W'(samples_per_fetch(width_sel, wide_mode));
                sb_d.wide = wide_mode;
            end
            sb_d.req = (sb_d.left == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sb_q <= '0;
        else        sb_q <= sb_d;
    end

    assign req    = sb_q.req;
    assign sample = sb_q.smp;

endmodule

// File: rtl/wide_audio_chan.sv
module wide_audio_chan #(
    parameter int PER_W  = 16,
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic [1:0]        width_sel,
    input  logic              wide_mode,
    input  logic [PER_W-1:0]  period,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  length_units,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_grant,
    input  logic [63:0]       fetch_data,
    output logic [15:0]       sample_out
);

    localparam int DATA_W = 64;

    logic expired;
    logic take;
    logic grant_ok;

    assign grant_ok = fetch_grant & fetch_req;

    wac_timer #(.PER_W(PER_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (chan_en),
        .period  (period),
        .reload  (take),
        .expired (expired)
    );

    wac_sample_buf #(.DATA_W(DATA_W)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (chan_en),
        .width_sel  (width_sel),
        .wide_mode  (wide_mode),
        .expired    (expired),
        .grant_ok   (grant_ok),
        .fetch_data (fetch_data),
        .take       (take),
        .req        (fetch_req),
        .sample     (sample_out)
    );

    wac_fetch_ctl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_fctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (chan_en),
        .width_sel    (width_sel),
        .start_addr   (start_addr),
        .length_units (length_units),
        .grant_ok     (grant_ok),
        .fetch_addr   (fetch_addr)
    );

endmodule

// File: rtl/wac_checker.sv
module wac_checker #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chan_en,
    input logic [1:0]        width_sel,
    input logic [ADDR_W-1:0] start_addr,
    input logic              fetch_req,
    input logic              fetch_grant,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic [15:0]       sample_out
);

    function automatic logic [ADDR_W-1:0] align_of(input logic [ADDR_W-1:0] a,
                                                    input logic [1:0]        w);
        logic [ADDR_W-1:0] m;
        case (w)
            2'd0:    m = ADDR_W'(1);
            2'd1:    m = ADDR_W'(3);
            default: m = ADDR_W'(7);
        endcase
        return a & ~m;
    endfunction

    // R2: an accepted grant fills the buffer, so the request drops
    assert_req_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && fetch_grant |=> !fetch_req);

    // R7: a pending request waits for its grant
    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && !fetch_grant && chan_en |=> fetch_req);

    // R11: disabling clears output and request
    assert_disable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> (sample_out == 16'h0000) && !fetch_req);

    // R9: while disabled the address follows the aligned start
    assert_start_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en && $stable(width_sel) |=>
            fetch_addr == align_of($past(start_addr), $past(width_sel)));

    // R12: a grant without a request moves nothing
    assert_no_stray_grant_R12: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en && fetch_grant && !fetch_req |=>
            $stable(fetch_addr) || !$stable(width_sel));

endmodule

bind wide_audio_chan wac_checker #(.ADDR_W(ADDR_W)) u_wac_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .chan_en     (chan_en),
    .width_sel   (width_sel),
    .start_addr  (start_addr),
    .fetch_req   (fetch_req),
    .fetch_grant (fetch_grant),
    .fetch_addr  (fetch_addr),
    .sample_out  (sample_out)
);

// File: tb/wide_audio_chan_bench.sv
module wide_audio_chan_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_en = 1'b0;
    logic [1:0]  width_sel = 2'd0;
    logic        wide_mode = 1'b0;
    logic [15:0] period = 16'd1;
    logic [23:0] start_addr = 24'h0;
    logic [15:0] length_units = 16'd1;
    logic        fetch_req;
    logic [23:0] fetch_addr;
    logic        fetch_grant = 1'b0;
    logic [63:0] fetch_data = 64'h0;
    logic [15:0] sample_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    wide_audio_chan u_wide_audio_chan (
        .clk          (clk),
        .rst_n        (rst_n),
        .chan_en      (chan_en),
        .width_sel    (width_sel),
        .wide_mode    (wide_mode),
        .period       (period),
        .start_addr   (start_addr),
        .length_units (length_units),
        .fetch_req    (fetch_req),
        .fetch_addr   (fetch_addr),
        .fetch_grant  (fetch_grant),
        .fetch_data   (fetch_data),
        .sample_out   (sample_out)
    );

    typedef struct packed {
        logic [1:0]  w;
        logic        wide;
        logic [15:0] per;
        logic [63:0] data;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [0:NVEC-1] = '{
        '{2'd0, 1'b0, 16'd3, 64'h1111_2222_3333_A57F},   // narrow legacy case
        '{2'd1, 1'b0, 16'd2, 64'hDEAD_BEEF_0180_FF12},
        '{2'd2, 1'b0, 16'd1, 64'h0123_4567_89AB_CDEF},
        '{2'd0, 1'b1, 16'd4, 64'h5555_6666_7777_8001},
        '{2'd1, 1'b1, 16'd1, 64'hFFFF_FFFF_7FFE_0002},
        '{2'd2, 1'b1, 16'd5, 64'hFEDC_BA98_7654_3210}
    };

    task automatic chk(input string rid, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rid, act, exp);
        end
    endtask

    function automatic int nbytes_of(input logic [1:0] w);
        return (w == 2'd0) ? 2 : (w == 2'd1) ? 4 : 8;
    endfunction

    function automatic logic [15:0] exp_smp(input logic [1:0] w, input logic wide,
                                            input logic [63:0] d, input int k);
        int sb;
        int sh;
        logic [63:0] t;
        sb = wide ? 16 : 8;
        sh = 8 * nbytes_of(w) - (k + 1) * sb;
        t  = d >> sh;
        return wide ? t[15:0] : {t[7:0], 8'h00};
    endfunction

    task automatic wait_req();
        for (int i = 0; i < 60; i++) begin
            if (fetch_req) break;
            @(negedge clk);
        end
    endtask

    task automatic grant_word(input logic [63:0] d);
        fetch_grant = 1'b1;
        fetch_data  = d;
        @(negedge clk);
        fetch_grant = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired, run hung (all requirements)");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] prev;
        logic [23:0] addr0;
        int          n;

        // R1: reset state
        #5;
        chk("R1 sample_out", 64'(sample_out), 64'h0);
        chk("R1 fetch_req", 64'(fetch_req), 64'h0);
        chk("R1 fetch_addr", 64'(fetch_addr), 64'h0);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // vector table: width, sample size, ordering, format, period, request timing
        for (int v = 0; v < NVEC; v++) begin
            chan_en   = 1'b0;
            width_sel = VECS[v].w;
            wide_mode = VECS[v].wide;
            period    = VECS[v].per;
            @(negedge clk);
            chan_en = 1'b1;
            @(negedge clk);
            chk("R2 req after enable", 64'(fetch_req), 64'h1);
            grant_word(VECS[v].data);
            chk("R2 req drops after grant", 64'(fetch_req), 64'h0);
            n = (8 * nbytes_of(VECS[v].w)) / (VECS[v].wide ? 16 : 8);
            @(negedge clk);
            // R3 R4 R5: first sample, one edge after load
            chk("R4 R5 first sample", 64'(sample_out), 64'(exp_smp(VECS[v].w, VECS[v].wide, VECS[v].data, 0)));
            chk("R7 req on sample 0", 64'(fetch_req), 64'(n == 1));
            prev = sample_out;
            for (int k = 1; k < n; k++) begin
                if (VECS[v].per > 1) begin
                    repeat (int'(VECS[v].per) - 1) @(negedge clk);
                    chk("R6 sample held", 64'(sample_out), 64'(prev));
                    @(negedge clk);
                end else begin
                    @(negedge clk);
                end
                chk("R3 R4 R5 R6 sample", 64'(sample_out), 64'(exp_smp(VECS[v].w, VECS[v].wide, VECS[v].data, k)));
                chk("R7 req with last sample", 64'(fetch_req), 64'(k == n - 1));
                prev = sample_out;
            end
        end

        // R12 then R8: stray grant, then underrun and refill
        chan_en   = 1'b0;
        width_sel = 2'd0;
        wide_mode = 1'b0;
        period    = 16'd4;
        start_addr   = 24'h000040;
        length_units = 16'd4;
        @(negedge clk);
        chan_en = 1'b1;
        wait_req();
        grant_word(64'h1020);
        @(negedge clk);
        chk("R4 sample 0 before stray grant", 64'(sample_out), 64'h1000);
        addr0 = fetch_addr;
        grant_word(64'hEEEE);   // fetch_req is low here
        chk("R12 address unchanged", 64'(fetch_addr), 64'(addr0));
        repeat (3) @(negedge clk);
        chk("R12 buffer unchanged", 64'(sample_out), 64'h2000);
        repeat (10) @(negedge clk);
        chk("R8 output held on underrun", 64'(sample_out), 64'h2000);
        chk("R7 req still pending", 64'(fetch_req), 64'h1);
        grant_word(64'h3040);
        @(negedge clk);
        chk("R8 sample after refill", 64'(sample_out), 64'h3000);

        // R11: disable mid-play
        chan_en = 1'b0;
        @(negedge clk);
        chk("R11 sample cleared", 64'(sample_out), 64'h0);
        chk("R11 req cleared", 64'(fetch_req), 64'h0);

        // R9: alignment of a misaligned start
        width_sel  = 2'd2;
        start_addr = 24'h001235;
        @(negedge clk);
        chk("R9 aligned start 64-bit", 64'(fetch_addr), 64'h001230);

        // R9 R10: stepping and looping, 32-bit fetches, length 3
        width_sel    = 2'd1;
        wide_mode    = 1'b0;
        period       = 16'd1;
        start_addr   = 24'h000100;
        length_units = 16'd3;
        @(negedge clk);
        chan_en = 1'b1;
        for (int g = 0; g < 4; g++) begin
            logic [23:0] ea;
            ea = (g == 3) ? 24'h000100 : 24'h000100 + 24'(4 * g);
            wait_req();
            chk("R9 R10 fetch address", 64'(fetch_addr), 64'(ea));
            grant_word(64'h0102_0304);
        end

        // R10: length 0 behaves as 1
        chan_en      = 1'b0;
        width_sel    = 2'd0;
        start_addr   = 24'h000200;
        length_units = 16'd0;
        @(negedge clk);
        chan_en = 1'b1;
        for (int g = 0; g < 2; g++) begin
            wait_req();
            chk("R10 length zero address", 64'(fetch_addr), 64'h000200);
            grant_word(64'h0A0B);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule